// File: doc/BRIEF.md
# Synchronous Trigger and Timestamp-Reset Interface

This block sits between a trigger decision unit and a device under test (DUT) that runs on the same clock, nominally 40 MHz, which is forwarded to it. Every accepted trigger request produces a trigger pulse one clock cycle wide. A run-start request produces a one-cycle timestamp-reset pulse on the sync line, so that both sides can zero their timestamps on the same edge. The DUT may hold its busy input high at any time to veto triggers.

In the optional numbered mode, the sync line also carries the trigger number. It is shifted out one bit per cycle, least-significant bit first, starting on the cycle right after the trigger pulse. While a number is on the line, new trigger requests are refused and flagged as rejected. A run-start request that arrives during a transfer is held until the line is free. It is then sent before any further trigger can be accepted.

Top module: `sync_trig_if`

## Requirements
- R1: While reset is asserted and in the first cycle after it, trig_out, sync_out, trig_accepted and trig_rejected are all 0.
- R2: A trigger request sampled at a clock edge with busy low, no transfer in progress and no timestamp reset issued at that edge drives trig_out and trig_accepted high for exactly the next cycle.
- R3: A trigger request sampled while busy is high produces no trigger pulse and drives trig_rejected high for the next cycle. Every request gives exactly one of accepted or rejected.
- R4: A run-start request sampled while the sync line is free drives sync_out high for exactly the next cycle.
- R5: When num_mode is 1 at the edge that accepts a trigger, the NUM_W bits of trig_num sampled at that edge appear on sync_out, bit 0 first, one per cycle, in the NUM_W cycles that follow the trigger pulse.
- R6: A trigger request sampled during any of the NUM_W transfer cycles is rejected.
- R7: A run-start request sampled during a transfer is held. Its timestamp-reset pulse comes in the cycle right after the last number bit, and a trigger request sampled at the edge that issues it is rejected.
- R8: When run_start and trig_req are sampled together with the line free, the timestamp reset is issued and the trigger request is rejected.
- R9: With num_mode 0, sync_out stays 0 after triggers, and requests on consecutive edges are each accepted.
- R10: num_mode and trig_num matter only at the accepting edge. Changing them later does not alter or start a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared trigger and DUT clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| trig_req | input | 1 | Trigger request from the decision logic |
| run_start | input | 1 | Start-of-run request for a timestamp reset |
| busy | input | 1 | DUT veto, high blocks triggers |
| num_mode | input | 1 | 1 = send the trigger number after each trigger |
| trig_num | input | NUM_W | Current trigger number |
| trig_out | output | 1 | Trigger line to the DUT |
| sync_out | output | 1 | Timestamp-reset and serial trigger-number line |
| trig_accepted | output | 1 | High in the cycle a trigger pulse is issued |
| trig_rejected | output | 1 | High in the cycle after a refused request |

## Verification
The sync line has two users, the timestamp reset and the number transfer, and they collide whenever run_start lands inside a transfer. A trigger request and a run start can also land on the same edge. The bench forces both cases: it raises run_start in the middle of a transfer, then raises trig_req again on the edge where the held reset is due, and separately presents both requests on one idle edge. A behavioural queue model predicts every output on every cycle, and directed checks confirm that the reset follows the last bit with no gap and that the colliding trigger is rejected.

// File: rtl/sync_trig_pkg.sv
package sync_trig_pkg;
  typedef enum logic [1:0] {
    REQ_NONE   = 2'd0,
    REQ_ACCEPT = 2'd1,
    REQ_REJECT = 2'd2
  } req_res_e;
endpackage

// File: rtl/sync_trig_t0.sv
module sync_trig_t0 (
  input  logic clk,
  input  logic rst_n,
  input  logic run_start,
  input  logic line_busy,
  output logic t0_fire
);
  logic pend_q;
  logic pend_d;
  logic want;

  always_comb begin
    want    = run_start | pend_q;
    pend_d  = want & line_busy;
    t0_fire = want & ~line_busy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end
endmodule

// File: rtl/sync_trig_gate.sv
module sync_trig_gate
  import sync_trig_pkg::*;
(
  input  logic     trig_req,
  input  logic     busy,
  input  logic     line_busy,
  input  logic     t0_fire,
  output req_res_e result
);
  always_comb begin
    if (!trig_req)                         result = REQ_NONE;
    else if (busy || line_busy || t0_fire) result = REQ_REJECT;
    else                                   result = REQ_ACCEPT;
  end
endmodule

// File: rtl/sync_trig_ser.sv
module sync_trig_ser #(
  parameter int NUM_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [NUM_W-1:0] num,
  output logic             active,
  output logic             bit_out
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [NUM_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             en;

  assign active  = (cnt_q != '0);
  assign bit_out = sh_q[0];
  assign en      = load | active;

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    if (load) begin
      sh_d  = num;
      cnt_d = CNT_W'(NUM_W);
    end else if (active) begin
      sh_d  = {1'b0, sh_q[NUM_W-1:1]};
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (en) begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/sync_trig_if.sv
module sync_trig_if
  import sync_trig_pkg::*;
#(
  parameter int NUM_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_req,
  input  logic             run_start,
  input  logic             busy,
  input  logic             num_mode,
  input  logic [NUM_W-1:0] trig_num,
  output logic             trig_out,
  output logic             sync_out,
  output logic             trig_accepted,
  output logic             trig_rejected
);
  logic     line_busy;
  logic     ser_bit;
  logic     t0_fire;
  logic     accept;
  req_res_e result;

  logic trig_d, sync_d, acc_d, rej_d;

  sync_trig_t0 u_t0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_start (run_start),
    .line_busy (line_busy),
    .t0_fire   (t0_fire)
  );

  sync_trig_gate u_gate (
    .trig_req  (trig_req),
    .busy      (busy),
    .line_busy (line_busy),
    .t0_fire   (t0_fire),
    .result    (result)
  );

  assign accept = (result == REQ_ACCEPT);

  sync_trig_ser #(.NUM_W(NUM_W)) u_ser (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept & num_mode),
    .num     (trig_num),
    .active  (line_busy),
    .bit_out (ser_bit)
  );

  always_comb begin
    trig_d = accept;
    acc_d  = accept;
    rej_d  = (result == REQ_REJECT);
    sync_d = t0_fire | (line_busy & ser_bit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_out      <= 1'b0;
      sync_out      <= 1'b0;
      trig_accepted <= 1'b0;
      trig_rejected <= 1'b0;
    end else begin
      trig_out      <= trig_d;
      sync_out      <= sync_d;
      trig_accepted <= acc_d;
      trig_rejected <= rej_d;
    end
  end
endmodule

// File: rtl/sync_trig_if_chk.sv
module sync_trig_if_chk (
  input logic clk,
  input logic rst_n,
  input logic trig_req,
  input logic run_start,
  input logic busy,
  input logic num_mode,
  input logic trig_out,
  input logic trig_accepted,
  input logic trig_rejected
);
  assert_trig_has_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    trig_out |-> ($past(trig_req) && !$past(busy)));

  assert_one_verdict_R3: assert property (@(posedge clk) disable iff (!rst_n)
    trig_req |=> (trig_accepted != trig_rejected));

  assert_busy_veto_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !trig_out);

  assert_no_trig_in_transfer_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_out && $past(num_mode)) |=> !trig_out);

  assert_t0_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run_start && trig_req) |=> (!trig_out && trig_rejected));
endmodule

bind sync_trig_if sync_trig_if_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .trig_req      (trig_req),
  .run_start     (run_start),
  .busy          (busy),
  .num_mode      (num_mode),
  .trig_out      (trig_out),
  .trig_accepted (trig_accepted),
  .trig_rejected (trig_rejected)
);

// File: tb/test_sync_trig_if.sv
module test_sync_trig_if;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic trig_req, run_start, busy, num_mode;
  logic [W-1:0] trig_num;
  logic trig_out, sync_out, trig_accepted, trig_rejected;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  sync_trig_if #(.NUM_W(W)) i_sync_trig_if (
    .clk(clk), .rst_n(rst_n), .trig_req(trig_req), .run_start(run_start),
    .busy(busy), .num_mode(num_mode), .trig_num(trig_num),
    .trig_out(trig_out), .sync_out(sync_out),
    .trig_accepted(trig_accepted), .trig_rejected(trig_rejected)
  );

  // behavioural reference: a queue of pending number bits and a held-reset flag
  bit q[$];
  bit pend_m;
  bit e_trig, e_sync, e_acc, e_rej;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete();
      pend_m = 0; e_trig = 0; e_sync = 0; e_acc = 0; e_rej = 0;
    end else begin
      bit on_line;
      bit fire;
      bit ok;
      on_line = (q.size() != 0);
      fire    = (run_start || pend_m) && !on_line;
      pend_m  = (run_start || pend_m) && on_line;
      ok      = trig_req && !busy && !on_line && !fire;
      e_trig  = ok;
      e_acc   = ok;
      e_rej   = trig_req && !ok;
      e_sync  = fire;
      if (on_line) e_sync = q.pop_front();
      if (ok && num_mode)
        for (int i = 0; i < W; i++) q.push_back(trig_num[i]);
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      n_chk++;
      if ({trig_out, sync_out, trig_accepted, trig_rejected} !==
          {e_trig, e_sync, e_acc, e_rej}) begin
        n_fail++;
        $display("FAIL model R2/R3/R5: outputs trig,sync,acc,rej=%b%b%b%b expected %b%b%b%b at cycle %0d",
                 trig_out, sync_out, trig_accepted, trig_rejected,
                 e_trig, e_sync, e_acc, e_rej, cycles);
      end
    end
    if (cycles > 5000) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, cycles %0d expected below 5000", cycles);
      report();
    end
  end

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: trig,sync,acc,rej actual %b expected %b", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] outs();
    return {trig_out, sync_out, trig_accepted, trig_rejected};
  endfunction

  task automatic cyc(input logic rq, input logic rs, input logic bz,
                     input logic md, input logic [W-1:0] nm);
    trig_req = rq; run_start = rs; busy = bz; num_mode = md; trig_num = nm;
    @(negedge clk);
  endtask

  task automatic send_num(input logic [W-1:0] v);
    cyc(1, 0, 0, 1, v);
    chk("R5 trigger before number", outs(), 4'b1010);
    for (int i = 0; i < W; i++) begin
      cyc(0, 0, 0, 0, ~v);
      chk("R5 number bit", outs(), {1'b0, v[i], 2'b00});
    end
  endtask

  initial begin
    rst_n = 0;
    trig_req = 0; run_start = 0; busy = 0; num_mode = 0; trig_num = '0;
    repeat (3) @(negedge clk);
    chk("R1 during reset", outs(), 4'b0000);
    rst_n = 1;
    cyc(0, 0, 0, 0, 0);
    chk("R1 after reset", outs(), 4'b0000);

    cyc(1, 0, 0, 0, 8'h11);
    chk("R2 accepted pulse", outs(), 4'b1010);
    cyc(0, 0, 0, 0, 0);
    chk("R2 pulse one cycle", outs(), 4'b0000);

    cyc(1, 0, 1, 0, 0);
    chk("R3 busy veto", outs(), 4'b0001);
    cyc(0, 0, 1, 0, 0);
    chk("R3 no request no verdict", outs(), 4'b0000);

    cyc(0, 1, 0, 0, 0);
    chk("R4 timestamp reset", outs(), 4'b0100);
    cyc(0, 0, 0, 0, 0);
    chk("R4 reset one cycle", outs(), 4'b0000);

    cyc(1, 0, 0, 0, 0);
    chk("R9 back-to-back first", outs(), 4'b1010);
    cyc(1, 0, 0, 0, 0);
    chk("R9 back-to-back second", outs(), 4'b1010);
    cyc(0, 0, 0, 1, 8'hFF);
    chk("R10 late mode change ignored", outs(), 4'b0000);
    cyc(0, 0, 0, 0, 0);
    chk("R9 R10 sync idle", outs(), 4'b0000);

    // transfer with a collision: request at bit 2, run start at bit 3,
    // mode and number changed throughout (R10)
    cyc(1, 0, 0, 1, 8'hA5);
    chk("R5 trigger in numbered mode", outs(), 4'b1010);
    for (int i = 0; i < W; i++) begin
      cyc(i == 2, i == 3, 0, i[0], 8'h3C);
      if (i == 2) chk("R6 request during transfer", outs(), {1'b0, 1'b1, 2'b01});
      else        chk("R5 R10 bit of A5", outs(), {1'b0, 8'hA5 >> i & 8'h01 ? 1'b1 : 1'b0, 2'b00});
    end
    cyc(1, 0, 0, 0, 0);
    chk("R7 held reset after last bit, request rejected", outs(), 4'b0101);
    cyc(1, 0, 0, 0, 0);
    chk("R7 trigger accepted after held reset", outs(), 4'b1010);
    cyc(0, 0, 0, 0, 0);
    chk("R7 line idle", outs(), 4'b0000);

    cyc(1, 1, 0, 0, 0);
    chk("R8 coincident run start wins", outs(), 4'b0101);
    cyc(0, 0, 0, 0, 0);

    send_num(8'h01);
    send_num(8'h80);
    cyc(0, 0, 0, 0, 0);
    chk("R5 line idle after transfer", outs(), 4'b0000);

    cyc(1, 0, 1, 1, 8'hFF);
    chk("R3 busy veto in numbered mode", outs(), 4'b0001);
    cyc(0, 0, 0, 0, 0);
    chk("R3 vetoed request starts no transfer", outs(), 4'b0000);

    report();
  end
endmodule